// File: doc/BRIEF.md
# Latency-Hiding Batch Dispatcher for Shader Quads

This block keeps a pool of pixel batches (each one a 4x4 tile of 16 pixels) and feeds them to a small set of shader quads. Each quad has four pipelines. Work is always given to a whole quad, never to a single pipeline. A rasterizer-side port offers new batches with a valid/ready handshake and names a home quad. The home quad's pool of slots limits how many batches may be in flight. The block answers with the batch ID it allocated.

Each batch slot is in one of five states: free, ready, running, waiting or done. Only ready batches are dispatched, and they go out oldest-first from a single shared ready queue. When a quad finishes its batch, the block reassigns it in the same clock edge. The same happens when the quad's batch blocks on a data fetch. The blocked batch is parked until a data-return tag carrying its ID arrives. It then re-enters the ready queue and may run on any quad. A finished batch keeps its slot for one more cycle. The slot is then freed, and its ID is reported on that quad's retire lane.

Top module: `thread_dispatcher`

## Requirements
- R1: After reset, `in_ready` is 1 for every home quad, and no `asg_valid` or `rt_valid` bit is set.
- R2: An accepted batch takes the lowest-numbered free slot of its home quad. Its ID is home_quad*SLOTS_PER_QUAD + slot, so the home quad sits in the upper ID bits. `in_id` shows this ID in the same cycle as the offer.
- R3: `in_ready` is 0 when every slot of the addressed home quad is not free. A done slot still counts as in use. A batch is taken only in a cycle where `in_valid` and `in_ready` are both 1.
- R4: At a clock edge where the ready queue is not empty, the head batch goes to the lowest-numbered quad that is either idle or reporting done or stall in that cycle. `asg_valid[q]` pulses for one cycle after that edge, with the ID in lane q of `asg_id`. At most one quad is assigned per edge.
- R5: Ready batches leave the queue in the order they became ready (oldest first). When a new batch and a woken batch become ready at the same edge, the new batch counts as the older.
- R6: `q_stall[q]` from a busy quad parks its batch as waiting. The quad takes another ready batch at that same edge.
- R7: A `ret_valid` whose `ret_id` names a waiting batch makes that batch ready again, and it may resume on any quad. A `ret_valid` for a batch that is not waiting has no effect.
- R8: `q_done[q]` from a busy quad marks its batch done. Two edges later the slot is free: `rt_valid[q]` is 1 for one cycle with the ID in lane q of `rt_id`, and `in_ready` for that home quad recovers.
- R9: If one quad reports done and stall in the same cycle, done wins. Done or stall from an idle quad is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | New batch offered |
| in_quad | input | QW | Home quad of the offered batch |
| in_ready | output | 1 | Home quad has a free slot |
| in_id | output | IDW | ID that the offered batch receives |
| q_done | input | NUM_QUADS | Per quad: current batch finished |
| q_stall | input | NUM_QUADS | Per quad: current batch blocked on a fetch |
| ret_valid | input | 1 | Data returned for a batch |
| ret_id | input | IDW | ID of the batch whose data returned |
| asg_valid | output | NUM_QUADS | Per quad: assignment pulse |
| asg_id | output | NUM_QUADS*IDW | Per-quad lanes of assigned batch IDs |
| rt_valid | output | NUM_QUADS | Per quad: retire pulse |
| rt_id | output | NUM_QUADS*IDW | Per-quad lanes of retired batch IDs |

## Verification
Two paths can fire together at one edge. One is a stall on one quad plus a completion on another, where both quads compete for a single head batch. The other is a wake-up and an intake that both push into the ready queue. The bench drives a stall on quad 0 and a done on quad 1 in one cycle while an intake is also pending. It checks that only quad 0 receives the oldest batch and that quad 1 gets the next one an edge later. In a separate scenario, a new batch and a data return arrive together while both quads are busy. The next two completions must draw the new batch first and the woken one second.

// File: rtl/td_pkg.sv
package td_pkg;

  typedef enum logic [2:0] {
    ST_FREE    = 3'd0,
    ST_READY   = 3'd1,
    ST_RUNNING = 3'd2,
    ST_WAITING = 3'd3,
    ST_DONE    = 3'd4
  } slot_state_e;

  // advance a circular pointer by n steps
  function automatic int ring_add(input int ptr, input int n, input int depth);
    int s;
    s = ptr + n;
    if (s >= depth) s = s - depth;
    return s;
  endfunction

  // batch ID: home quad in the upper part, slot in the lower part
  function automatic int batch_id(input int home, input int slot, input int slots);
    return home * slots + slot;
  endfunction

endpackage

// File: rtl/td_ready_fifo.sv
module td_ready_fifo
  import td_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int W     = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_a,
  input  logic [W-1:0] din_a,
  input  logic         push_b,
  input  logic [W-1:0] din_b,
  input  logic         pop,
  output logic [W-1:0] head,
  output logic         empty
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] rd_ptr, wr_ptr, wr_b;
  logic [CW-1:0] cnt;
  logic [1:0]    n_push;

  always_comb begin
    n_push = {1'b0, push_a} + {1'b0, push_b};
    wr_b   = push_a ? PW'(ring_add(int'(wr_ptr), 1, DEPTH)) : wr_ptr;
  end

  // port a (intake) is written ahead of port b (wake-up): it counts as older
  always_ff @(posedge clk) begin
    if (push_a) mem[wr_ptr] <= din_a;
    if (push_b) mem[wr_b]   <= din_b;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
    end else begin
      wr_ptr <= PW'(ring_add(int'(wr_ptr), int'(n_push), DEPTH));
      if (pop) rd_ptr <= PW'(ring_add(int'(rd_ptr), 1, DEPTH));
      cnt <= cnt + CW'(n_push) - CW'(pop);
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (cnt == '0);

  p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  p_fill_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

endmodule

// File: rtl/td_slot_table.sv
module td_slot_table
  import td_pkg::*;
#(
  parameter int NQ    = 2,
  parameter int SLOTS = 16,
  parameter int QW    = 1,
  parameter int IDW   = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           alloc_req,
  input  logic [QW-1:0]  alloc_quad,
  output logic           alloc_ok,
  output logic           alloc_fire,
  output logic [IDW-1:0] alloc_id,
  input  logic           run_en,
  input  logic [IDW-1:0] run_id,
  input  logic [NQ-1:0]  stall_en,
  input  logic [IDW-1:0] stall_id [NQ],
  input  logic [NQ-1:0]  done_en,
  input  logic [IDW-1:0] done_id [NQ],
  input  logic [NQ-1:0]  free_en,
  input  logic [IDW-1:0] free_id [NQ],
  input  logic           ret_valid,
  input  logic [IDW-1:0] ret_id,
  output logic           wake_en
);
  localparam int TOTAL = NQ * SLOTS;

  slot_state_e st [TOTAL];

  // lowest free slot of the addressed home quad
  always_comb begin
    alloc_ok = 1'b0;
    alloc_id = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (st[batch_id(int'(alloc_quad), s, SLOTS)] == ST_FREE) begin
        alloc_ok = 1'b1;
        alloc_id = IDW'(batch_id(int'(alloc_quad), s, SLOTS));
      end
    end
  end

  assign alloc_fire = alloc_req && alloc_ok;
  assign wake_en    = ret_valid && (st[ret_id] == ST_WAITING);

  // every write targets a slot in a distinct state, so no two collide
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < TOTAL; i++) st[i] <= ST_FREE;
    end else begin
      for (int q = 0; q < NQ; q++)
        if (free_en[q]) st[free_id[q]] <= ST_FREE;
      if (alloc_fire) st[alloc_id] <= ST_READY;
      if (run_en)     st[run_id]   <= ST_RUNNING;
      for (int q = 0; q < NQ; q++) begin
        if (done_en[q])       st[done_id[q]]  <= ST_DONE;
        else if (stall_en[q]) st[stall_id[q]] <= ST_WAITING;
      end
      if (wake_en) st[ret_id] <= ST_READY;
    end
  end

  p_run_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> st[run_id] == ST_READY);

  for (genvar q = 0; q < NQ; q++) begin : g_chk
    p_stall_running_r6: assert property (@(posedge clk) disable iff (!rst_n)
      stall_en[q] |-> st[stall_id[q]] == ST_RUNNING);
    p_free_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      free_en[q] |-> st[free_id[q]] == ST_DONE);
  end

endmodule

// File: rtl/td_quad_lane.sv
module td_quad_lane #(
  parameter int IDW = 5
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           done_in,
  input  logic           stall_in,
  input  logic           grant,
  input  logic [IDW-1:0] grant_id,
  output logic           wants,
  output logic           done_fire,
  output logic           stall_fire,
  output logic [IDW-1:0] cur_id,
  output logic           asg_valid,
  output logic [IDW-1:0] asg_id,
  output logic           rt_valid,
  output logic [IDW-1:0] rt_id,
  output logic           free_en,
  output logic [IDW-1:0] free_id
);
  logic           busy;
  logic           done_pend;
  logic [IDW-1:0] done_pid;

  // done outranks stall; both are ignored while idle
  assign done_fire  = busy && done_in;
  assign stall_fire = busy && stall_in && !done_in;
  assign wants      = !busy || done_fire || stall_fire;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      cur_id    <= '0;
      asg_valid <= 1'b0;
      asg_id    <= '0;
      done_pend <= 1'b0;
      done_pid  <= '0;
      rt_valid  <= 1'b0;
      rt_id     <= '0;
    end else begin
      if (grant) begin
        busy   <= 1'b1;
        cur_id <= grant_id;
      end else if (done_fire || stall_fire) begin
        busy <= 1'b0;
      end
      asg_valid <= grant;
      if (grant) asg_id <= grant_id;
      done_pend <= done_fire;
      done_pid  <= cur_id;
      rt_valid  <= done_pend;
      rt_id     <= done_pid;
    end
  end

  assign free_en = done_pend;
  assign free_id = done_pid;

  p_grant_wants_r4: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> wants);

  p_retire_two_edges_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_fire |=> ##1 (rt_valid && rt_id == $past(cur_id, 2)));

endmodule

// File: rtl/thread_dispatcher.sv
module thread_dispatcher
  import td_pkg::*;
#(
  parameter  int NUM_QUADS      = 2,
  parameter  int SLOTS_PER_QUAD = 16,
  localparam int QW  = (NUM_QUADS > 1) ? $clog2(NUM_QUADS) : 1,
  localparam int IDW = $clog2(NUM_QUADS * SLOTS_PER_QUAD)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  input  logic [QW-1:0]            in_quad,
  output logic                     in_ready,
  output logic [IDW-1:0]           in_id,
  input  logic [NUM_QUADS-1:0]     q_done,
  input  logic [NUM_QUADS-1:0]     q_stall,
  input  logic                     ret_valid,
  input  logic [IDW-1:0]           ret_id,
  output logic [NUM_QUADS-1:0]     asg_valid,
  output logic [NUM_QUADS*IDW-1:0] asg_id,
  output logic [NUM_QUADS-1:0]     rt_valid,
  output logic [NUM_QUADS*IDW-1:0] rt_id
);
  localparam int TOTAL = NUM_QUADS * SLOTS_PER_QUAD;

  logic                 alloc_fire;
  logic                 wake_en;
  logic [IDW-1:0]       q_head;
  logic                 q_empty;
  logic                 pop;
  logic [NUM_QUADS-1:0] wants, grant, done_fire, stall_fire, free_en;
  logic [IDW-1:0]       cur_id  [NUM_QUADS];
  logic [IDW-1:0]       free_id [NUM_QUADS];

  // fixed-priority choice: lowest quad that can take work
  always_comb begin
    logic found;
    found = 1'b0;
    grant = '0;
    if (!q_empty) begin
      for (int q = 0; q < NUM_QUADS; q++) begin
        if (wants[q] && !found) begin
          grant[q] = 1'b1;
          found    = 1'b1;
        end
      end
    end
  end

  assign pop = |grant;

  td_slot_table #(
    .NQ(NUM_QUADS), .SLOTS(SLOTS_PER_QUAD), .QW(QW), .IDW(IDW)
  ) table_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .alloc_req (in_valid),
    .alloc_quad(in_quad),
    .alloc_ok  (in_ready),
    .alloc_fire(alloc_fire),
    .alloc_id  (in_id),
    .run_en    (pop),
    .run_id    (q_head),
    .stall_en  (stall_fire),
    .stall_id  (cur_id),
    .done_en   (done_fire),
    .done_id   (cur_id),
    .free_en   (free_en),
    .free_id   (free_id),
    .ret_valid (ret_valid),
    .ret_id    (ret_id),
    .wake_en   (wake_en)
  );

  td_ready_fifo #(.DEPTH(TOTAL), .W(IDW)) ready_q_i (
    .clk   (clk),
    .rst_n (rst_n),
    .push_a(alloc_fire),
    .din_a (in_id),
    .push_b(wake_en),
    .din_b (ret_id),
    .pop   (pop),
    .head  (q_head),
    .empty (q_empty)
  );

  for (genvar q = 0; q < NUM_QUADS; q++) begin : g_lane
    td_quad_lane #(.IDW(IDW)) lane_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .done_in   (q_done[q]),
      .stall_in  (q_stall[q]),
      .grant     (grant[q]),
      .grant_id  (q_head),
      .wants     (wants[q]),
      .done_fire (done_fire[q]),
      .stall_fire(stall_fire[q]),
      .cur_id    (cur_id[q]),
      .asg_valid (asg_valid[q]),
      .asg_id    (asg_id[q*IDW +: IDW]),
      .rt_valid  (rt_valid[q]),
      .rt_id     (rt_id[q*IDW +: IDW]),
      .free_en   (free_en[q]),
      .free_id   (free_id[q])
    );
  end

  p_one_dispatch_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(asg_valid));

  p_wake_enqueues_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_en |=> !q_empty);

endmodule

// File: tb/thread_dispatcher_tb_top.sv
module thread_dispatcher_tb_top;
  localparam int CLK_P = 10;
  localparam int NQ    = 2;
  localparam int SL    = 16;
  localparam int IDW   = 5;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              in_valid;
  logic [0:0]        in_quad;
  logic              in_ready;
  logic [IDW-1:0]    in_id;
  logic [NQ-1:0]     q_done, q_stall;
  logic              ret_valid;
  logic [IDW-1:0]    ret_id;
  logic [NQ-1:0]     asg_valid, rt_valid;
  logic [NQ*IDW-1:0] asg_id, rt_id;

  int total = 0;
  int bad   = 0;

  always #(CLK_P/2) clk = ~clk;

  thread_dispatcher #(.NUM_QUADS(NQ), .SLOTS_PER_QUAD(SL)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_quad(in_quad),
    .in_ready(in_ready), .in_id(in_id), .q_done(q_done), .q_stall(q_stall),
    .ret_valid(ret_valid), .ret_id(ret_id), .asg_valid(asg_valid),
    .asg_id(asg_id), .rt_valid(rt_valid), .rt_id(rt_id)
  );

  function automatic int bid(input int home, input int slot);
    return (home << 4) | slot;
  endfunction

  function automatic int aid(input int q);
    return int'(asg_id[q*IDW +: IDW]);
  endfunction

  function automatic int tid(input int q);
    return int'(rt_id[q*IDW +: IDW]);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(CLK_P/4);
  endtask

  task automatic clear_in();
    in_valid = 0; in_quad = 0; q_done = 0; q_stall = 0;
    ret_valid = 0; ret_id = 0;
  endtask

  task automatic do_reset();
    clear_in();
    rst_n = 0;
    repeat (3) tick();
    rst_n = 1;
    tick();
  endtask

  task automatic t_reset();
    do_reset();
    #1;
    chk("R1 in_ready", int'(in_ready), 1);
    chk("R1 asg_valid", int'(asg_valid), 0);
    chk("R1 rt_valid", int'(rt_valid), 0);
  endtask

  // stall on q0 and done on q1 in one cycle; resume on another quad
  task automatic t_switch();
    do_reset();
    in_valid = 1; in_quad = 0; #1;
    chk("R3 ready", int'(in_ready), 1);
    chk("R2 first id", int'(in_id), bid(0, 0));
    tick();
    chk("R4 no early asg", int'(asg_valid), 0);
    #1 chk("R2 next id", int'(in_id), bid(0, 1));
    tick();
    chk("R4 q0 asg", int'(asg_valid), 1);
    chk("R4 q0 id", aid(0), 0);
    tick();
    chk("R4 q1 asg", int'(asg_valid), 2);
    chk("R4 q1 id", aid(1), 1);
    tick();
    chk("R4 all busy", int'(asg_valid), 0);
    in_valid = 0; q_stall = 2'b01; q_done = 2'b10;
    tick();
    chk("R6 single switch", int'(asg_valid), 1);
    chk("R5 oldest to q0", aid(0), 2);
    clear_in();
    tick();
    chk("R4 q1 next", int'(asg_valid), 2);
    chk("R5 next id", aid(1), 3);
    chk("R8 retire q1", int'(rt_valid), 2);
    chk("R8 retire id", tid(1), 1);
    ret_valid = 1; ret_id = 0;
    tick();
    chk("R7 queue was empty", int'(asg_valid), 0);
    chk("R8 retire once", int'(rt_valid), 0);
    clear_in(); q_done = 2'b10;
    tick();
    chk("R7 resume other quad", int'(asg_valid), 2);
    chk("R7 resume id", aid(1), 0);
    clear_in();
    tick();
    chk("R8 retire lane1", int'(rt_valid), 2);
    chk("R8 retire id3", tid(1), 3);
  endtask

  // new batch and woken batch ready together; done beats stall
  task automatic t_order();
    do_reset();
    in_valid = 1; in_quad = 0;
    tick(); tick();
    in_valid = 0;
    tick();
    chk("R4 both busy", int'(asg_valid), 2);
    in_valid = 1; q_stall = 2'b01;
    tick();
    chk("R6 nothing ready", int'(asg_valid), 0);
    clear_in();
    tick();
    chk("R4 q0 takes id2", aid(0), 2);
    in_valid = 1; ret_valid = 1; ret_id = 0; #1;
    chk("R2 reuse slot3", int'(in_id), 3);
    tick();
    chk("R5 no free quad", int'(asg_valid), 0);
    clear_in(); q_done = 2'b10;
    tick();
    chk("R5 new first", int'(asg_valid), 2);
    chk("R5 new id", aid(1), 3);
    clear_in(); q_done = 2'b01;
    tick();
    chk("R5 woken second", int'(asg_valid), 1);
    chk("R7 woken id", aid(0), 0);
    clear_in(); q_done = 2'b10; q_stall = 2'b10;
    tick();
    chk("R8 lane0 retire", int'(rt_valid), 1);
    chk("R8 lane0 id", tid(0), 2);
    clear_in();
    tick();
    chk("R9 done wins", int'(rt_valid), 2);
    chk("R9 retired id", tid(1), 3);
  endtask

  // fill one home quad, then free a slot
  task automatic t_capacity();
    do_reset();
    in_valid = 1; in_quad = 1;
    for (int i = 0; i < SL; i++) begin
      #1;
      chk("R3 room", int'(in_ready), 1);
      chk("R2 id order", int'(in_id), bid(1, i));
      tick();
    end
    #1 chk("R3 full", int'(in_ready), 0);
    in_valid = 0; in_quad = 0; #1;
    chk("R3 other quad", int'(in_ready), 1);
    in_quad = 1;
    q_done = 2'b01;
    tick();
    chk("R4 refill on done", int'(asg_valid), 1);
    chk("R5 head id", aid(0), bid(1, 2));
    #1 chk("R3 done holds slot", int'(in_ready), 0);
    clear_in(); in_quad = 1;
    tick();
    chk("R8 retire", int'(rt_valid), 1);
    chk("R8 retire id", tid(0), bid(1, 0));
    #1 chk("R8 room back", int'(in_ready), 1);
    chk("R2 freed slot", int'(in_id), bid(1, 0));
  endtask

  // returns for non-waiting batches and events from an idle quad
  task automatic t_ignored();
    do_reset();
    in_valid = 1; in_quad = 0;
    tick();
    in_valid = 0;
    tick();
    chk("R4 q0 id0", aid(0), 0);
    ret_valid = 1; ret_id = 0;
    tick();
    clear_in();
    tick();
    chk("R7 running not woken", int'(asg_valid), 0);
    ret_valid = 1; ret_id = 5;
    tick();
    clear_in();
    tick();
    chk("R7 free not woken", int'(asg_valid), 0);
    q_done = 2'b10; q_stall = 2'b10;
    tick();
    clear_in();
    tick();
    chk("R9 idle done ignored", int'(rt_valid), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog all act=hung exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_switch();
    t_order();
    t_capacity();
    t_ignored();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule